// File: doc/BRIEF.md
# Backlight Dimming Mode Controller

This block is the digital dimming core of an LED backlight driver. A host writes an 8-bit brightness value and a control word with an enable bit, a source-select bit and a mode bit through a small register port. The port has an address, write data, a write strobe and combinational read data. The block also measures the duty cycle of an external PWM input and turns it into an 8-bit fraction.

The source-select and mode bits choose the effective brightness. It can be the host value alone, the external duty alone, or the rounded product of the two. That product mode is for power-saving dimming, where the display engine trims the level the host set. The effective brightness drives an 8-bit PWM output. A new duty takes effect only at the counter wraparound, so the output never glitches.

Clearing the enable bit turns the output off at once. Setting it starts a soft-start interval of parameterised length. After that interval the output runs, and the status bit reports the backlight as on if the effective brightness is non-zero.

Top module: `bl_dim_ctrl`

## Requirements
- R1: Address 0x00 holds the 8-bit host brightness. It resets to 0 and reads back the last value written.
- R2: Address 0x01 is the control word: bit 0 enable, bit 1 source select, bit 2 mode. Bits 7..3 are ignored on write and read as 0. The word resets to 0x00.
- R3: Address 0x02 reads bit 3 as the backlight-on status and all other bits as 0. Writes to 0x02 have no effect. Any other address reads 0.
- R4: With source select = 1, the effective brightness equals the measured external duty, whatever the mode bit holds.
- R5: With source select = 0 and mode = 1, the effective brightness equals the host brightness.
- R6: With source select = 0 and mode = 0, the effective brightness is min(255, (B*F + 127) >> 8). Here B is the host brightness and F is the measured duty, except that a duty of 255 counts as 256, so a full duty returns B unchanged.
- R7: The measured duty is min(255, floor(H*256/P)), where H is the count of high cycles and P the count of cycles in each external period between rising edges. An input held high for TIMEOUT_CYC cycles measures 255. An input held low for TIMEOUT_CYC cycles measures 0.
- R8: While running, any 256 consecutive cycles of the PWM output contain E high cycles for an effective brightness E below 255, and 256 high cycles for E = 255. A new value is taken only when the 8-bit counter wraps.
- R9: From the clock edge that writes enable = 0, the PWM output is low and the status is 0.
- R10: After the edge that writes enable = 1, the output stays low and the status stays 0 for SS_CYC cycles. The status then rises no later than SS_CYC + 2 cycles after the write, provided the effective brightness is non-zero.
- R11: An effective brightness of 0 keeps the status at 0 and the PWM output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pwm_in | input | 1 | External PWM dimming input (asynchronous) |
| pwm_out | output | 1 | PWM dimming output |
| bl_on | output | 1 | Backlight-on status, same as bit 3 of address 0x02 |

## Verification
A wrong effective brightness shows up as a wrong count of high cycles in the PWM output within two 256-cycle frames. The status bit shows at once whether that brightness is zero. A bad duty measurement needs a few external periods to appear in the product and pass-through modes, and a broken stuck-input timeout needs TIMEOUT_CYC cycles. A faulty soft-start counter shifts the rise of the status bit off its window of SS_CYC cycles after the enable write. An error in the off path leaves the output or the status high on the cycle after the disabling write.

// File: rtl/bl_dim_pkg.sv
package bl_dim_pkg;

  localparam int BRT_W      = 8;
  localparam int MEAS_MAX_W = 16;

  localparam logic [7:0] ADDR_BRT  = 8'h00;
  localparam logic [7:0] ADDR_CTL  = 8'h01;
  localparam logic [7:0] ADDR_STAT = 8'h02;
  localparam int         STAT_ON_BIT = 3;

  localparam logic [BRT_W-1:0] BRT_FULL = '1;

  typedef enum logic [1:0] {
    SRC_PRODUCT = 2'b00,
    SRC_HOST    = 2'b01,
    SRC_EXT     = 2'b10
  } src_e;

  // Source select wins over mode; mode picks host vs product.
  function automatic src_e pick_source(input logic sel, input logic md);
    if (sel)     return SRC_EXT;
    else if (md) return SRC_HOST;
    else         return SRC_PRODUCT;
  endfunction

  // high/period ratio scaled to 256 steps, saturated at 255.
  function automatic logic [BRT_W-1:0] duty_norm(
    input logic [MEAS_MAX_W-1:0] high_c,
    input logic [MEAS_MAX_W-1:0] period_c);
    logic [MEAS_MAX_W+BRT_W-1:0] num;
    logic [MEAS_MAX_W+BRT_W-1:0] quo;
    if (period_c == '0) return '0;
    num = {high_c, {BRT_W{1'b0}}};
    quo = num / {{BRT_W{1'b0}}, period_c};
    if (quo > {{MEAS_MAX_W{1'b0}}, BRT_FULL}) return BRT_FULL;
    return quo[BRT_W-1:0];
  endfunction

  // Rounded product; a full duty counts as unity gain.
  function automatic logic [BRT_W-1:0] scale_brt(
    input logic [BRT_W-1:0] brt,
    input logic [BRT_W-1:0] duty);
    logic [BRT_W:0]     fac;
    logic [2*BRT_W+1:0] prod;
    logic [BRT_W+1:0]   res;
    fac  = (duty == BRT_FULL) ? {1'b1, {BRT_W{1'b0}}} : {1'b0, duty};
    prod = ({{(BRT_W+2){1'b0}}, brt} * {{(BRT_W+1){1'b0}}, fac})
           + (2*BRT_W+2)'(127);
    res  = prod[2*BRT_W+1:BRT_W];
    if (res > {2'b00, BRT_FULL}) return BRT_FULL;
    return res[BRT_W-1:0];
  endfunction

endpackage

// File: rtl/bl_duty_meter.sv
module bl_duty_meter
  import bl_dim_pkg::*;
#(
  parameter int MEAS_W      = 12,
  parameter int TIMEOUT_CYC = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  output logic [BRT_W-1:0] duty,
  output logic             in_rise
);
  localparam int RUN_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [MEAS_W-1:0] MEAS_SAT = '1;
  localparam logic [RUN_W-1:0]  RUN_LIM  = RUN_W'(TIMEOUT_CYC);

  logic              sync1, sync2, sync_prev;
  logic [MEAS_W-1:0] per_cnt, hi_cnt;
  logic [RUN_W-1:0]  run_cnt;
  logic              in_change;

  assign in_rise   = sync2 & ~sync_prev;
  assign in_change = sync2 ^ sync_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= 1'b0;
      sync2     <= 1'b0;
      sync_prev <= 1'b0;
    end else begin
      sync1     <= pwm_in;
      sync2     <= sync1;
      sync_prev <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      hi_cnt  <= '0;
      run_cnt <= '0;
      duty    <= '0;
    end else begin
      if (in_rise) begin
        duty    <= duty_norm(MEAS_MAX_W'(hi_cnt), MEAS_MAX_W'(per_cnt));
        per_cnt <= MEAS_W'(1);
        hi_cnt  <= MEAS_W'(1);
      end else begin
        if (per_cnt != MEAS_SAT) per_cnt <= per_cnt + 1'b1;
        if (sync2 && hi_cnt != MEAS_SAT) hi_cnt <= hi_cnt + 1'b1;
      end
      if (in_change) begin
        run_cnt <= '0;
      end else if (run_cnt != RUN_LIM) begin
        run_cnt <= run_cnt + 1'b1;
        if (run_cnt == RUN_LIM - 1'b1) duty <= sync2 ? BRT_FULL : '0;
      end
    end
  end
endmodule

// File: rtl/bl_softstart.sv
module bl_softstart #(
  parameter int SS_CYC = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic done
);
  localparam int CNT_W = $clog2(SS_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SS_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!enable) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (cnt == CNT_END) done <= 1'b1;
      else                cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_dim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRT_W-1:0] duty_next,
  output logic [BRT_W-1:0] duty_act,
  output logic             wrap,
  output logic             pwm_raw
);
  logic [BRT_W-1:0] cnt;

  assign wrap    = (cnt == BRT_FULL);
  assign pwm_raw = (duty_act == BRT_FULL) | (cnt < duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      duty_act <= '0;
    end else begin
      cnt <= cnt + 1'b1;
      if (wrap) duty_act <= duty_next;
    end
  end
endmodule

// File: rtl/bl_dim_ctrl.sv
module bl_dim_ctrl
  import bl_dim_pkg::*;
#(
  parameter int MEAS_W      = 12,
  parameter int TIMEOUT_CYC = 2048,
  parameter int SS_CYC      = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       pwm_in,
  output logic       pwm_out,
  output logic       bl_on
);
  logic [BRT_W-1:0] brt_q;
  logic             en_q, sel_q, md_q;
  logic [BRT_W-1:0] ext_duty;
  logic             ext_rise;
  logic [BRT_W-1:0] eff_brt;
  logic [BRT_W-1:0] active_duty;
  logic             pwm_wrap;
  logic             pwm_raw;
  logic             ss_done;
  logic             out_gate;
  src_e             src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brt_q <= '0;
      en_q  <= 1'b0;
      sel_q <= 1'b0;
      md_q  <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_BRT) brt_q <= reg_wdata;
      if (reg_addr == ADDR_CTL) begin
        en_q  <= reg_wdata[0];
        sel_q <= reg_wdata[1];
        md_q  <= reg_wdata[2];
      end
    end
  end

  bl_duty_meter #(
    .MEAS_W     (MEAS_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_in (pwm_in),
    .duty   (ext_duty),
    .in_rise(ext_rise)
  );

  assign src = pick_source(sel_q, md_q);

  always_comb begin
    unique case (src)
      SRC_EXT:  eff_brt = ext_duty;
      SRC_HOST: eff_brt = brt_q;
      default:  eff_brt = scale_brt(brt_q, ext_duty);
    endcase
  end

  bl_softstart #(.SS_CYC(SS_CYC)) u_ss (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(en_q),
    .done  (ss_done)
  );

  bl_pwm_gen u_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .duty_next(eff_brt),
    .duty_act (active_duty),
    .wrap     (pwm_wrap),
    .pwm_raw  (pwm_raw)
  );

  assign out_gate = en_q & ss_done;
  assign pwm_out  = pwm_raw & out_gate;
  assign bl_on    = out_gate & (eff_brt != '0);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_BRT)  reg_rdata = brt_q;
    if (reg_addr == ADDR_CTL)  reg_rdata = {5'b0, md_q, sel_q, en_q};
    if (reg_addr == ADDR_STAT) reg_rdata[STAT_ON_BIT] = bl_on;
  end
endmodule

// File: rtl/bl_dim_ctrl_chk.sv
module bl_dim_ctrl_chk #(
  parameter int SS_CYC = 400000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       pwm_out,
  input logic       bl_on,
  input logic [7:0] eff_brt,
  input logic [7:0] active_duty,
  input logic       pwm_wrap,
  input logic       en_q,
  input logic       ss_done
);
  localparam int LW = $clog2(SS_CYC + 4) + 1;
  logic [LW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wait_cnt <= '0;
    else if (!en_q || ss_done) wait_cnt <= '0;
    else                       wait_cnt <= wait_cnt + 1'b1;
  end

  // R2: reserved control bits always read as zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h01) |-> (reg_rdata[7:3] == 5'b0));

  // R3: status word carries only bit 3
  a_r3_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h02) |-> ((reg_rdata & 8'hF7) == 8'h00));

  // R8: active duty changes only at counter wrap
  a_r8_update_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_wrap |=> $stable(active_duty));

  // R9: disabling write silences output and status on the next cycle
  a_r9_off_at_once: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h01 && !reg_wdata[0]) |=> (!pwm_out && !bl_on));

  // R10: soft start finishes within its window
  a_r10_ss_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= LW'(SS_CYC + 1));

  // R11: zero brightness never reports on
  a_r11_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    bl_on |-> (eff_brt != 8'h00));

  // R8: a running full duty holds the output high
  a_r8_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (active_duty == 8'hFF && en_q && ss_done) |-> pwm_out);
endmodule

bind bl_dim_ctrl bl_dim_ctrl_chk #(.SS_CYC(SS_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .pwm_out    (pwm_out),
  .bl_on      (bl_on),
  .eff_brt    (eff_brt),
  .active_duty(active_duty),
  .pwm_wrap   (pwm_wrap),
  .en_q       (en_q),
  .ss_done    (ss_done)
);

// File: tb/test_bl_dim_ctrl.sv
`timescale 1ns/1ps
module test_bl_dim_ctrl;
  localparam int TO_CYC = 1000;
  localparam int SS     = 64;
  localparam int EXT_P  = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       pwm_in = 1'b0;
  logic       pwm_out;
  logic       bl_on;

  int checks = 0;
  int fails  = 0;
  int ext_h  = 50;
  int ext_mode = 0; // 0 toggling, 1 stuck high, 2 stuck low
  int ph = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bl_dim_ctrl #(.MEAS_W(12), .TIMEOUT_CYC(TO_CYC), .SS_CYC(SS)) i_bl_dim_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_in(pwm_in),
    .pwm_out(pwm_out), .bl_on(bl_on));

  always @(negedge clk) begin
    if (ext_mode == 0) begin
      pwm_in <= (ph < ext_h);
      ph = (ph >= EXT_P - 1) ? 0 : ph + 1;
    end else begin
      pwm_in <= (ext_mode == 1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic count_high(output int n);
    n = 0;
    repeat (256) begin
      @(negedge clk);
      if (pwm_out) n++;
    end
  endtask

  // Independent model of the brightness path.
  function automatic int model_eff(input int sel, input int md, input int b, input int d);
    int f;
    if (sel != 0) return d;
    if (md != 0) return b;
    f = (d == 255) ? 256 : d;
    return ((b * f + 127) / 256 > 255) ? 255 : (b * f + 127) / 256;
  endfunction

  function automatic int model_duty(input int h);
    int q;
    q = (h * 256) / EXT_P;
    return (q > 255) ? 255 : q;
  endfunction

  function automatic int model_count(input int e);
    return (e == 255) ? 256 : e;
  endfunction

  // {sel, md, brt[7:0], high[7:0]}
  localparam logic [17:0] VEC [7] = '{
    {1'b0, 1'b1, 8'd200, 8'd50},
    {1'b0, 1'b0, 8'd200, 8'd50},
    {1'b0, 1'b0, 8'd200, 8'd25},
    {1'b1, 1'b0, 8'd200, 8'd25},
    {1'b1, 1'b1, 8'd10,  8'd99},
    {1'b0, 1'b1, 8'd255, 8'd50},
    {1'b0, 1'b0, 8'd0,   8'd50}
  };

  initial begin
    int v, n, e, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1, R2, R3 reset state
    rd(8'h00, v); check("R1 reset brightness", v, 0);
    rd(8'h01, v); check("R2 reset control", v, 0);
    rd(8'h02, v); check("R3 reset status", v, 0);
    check("R10 output low while disabled", pwm_out, 0);

    wr(8'h00, 8'hA5);
    rd(8'h00, v); check("R1 readback", v, 8'hA5);
    wr(8'h01, 8'hFA);
    rd(8'h01, v); check("R2 reserved bits ignored", v, 8'h02);
    wr(8'h02, 8'hFF);
    rd(8'h02, v); check("R3 status write ignored", v, 0);
    rd(8'h07, v); check("R3 unmapped read", v, 0);

    // R10 soft-start timing, host mode brightness 0xA5
    wr(8'h01, 8'h05);
    t = 1;
    while (!bl_on && t < SS + 10) begin
      if (pwm_out) begin
        check("R10 output low during soft start", 1, 0);
      end
      @(negedge clk); t++;
    end
    checks++;
    if (t < SS - 1 || t > SS + 2) begin
      fails++;
      $display("FAIL R10: status rose after %0d cycles expected about %0d", t, SS);
    end
    rd(8'h02, v); check("R3 status bit 3 when on", v, 8'h08);

    // Table of modes, R4 R5 R6 R7 R8
    for (int i = 0; i < 7; i++) begin
      ext_h = VEC[i][7:0];
      wr(8'h00, VEC[i][15:8]);
      wr(8'h01, {5'b0, VEC[i][16], VEC[i][17], 1'b1});
      repeat (700) @(negedge clk);
      count_high(n);
      e = model_eff(VEC[i][17], VEC[i][16], VEC[i][15:8], model_duty(VEC[i][7:0]));
      check($sformatf("R8 R4 R5 R6 R7 vector %0d", i), n, model_count(e));
      if (e == 0) check("R11 zero brightness status", bl_on, 0);
      else        check("R11 nonzero brightness status", bl_on, 1);
    end

    // R7 stuck high -> 255, pass-through
    ext_mode = 1;
    wr(8'h01, 8'h03);
    repeat (TO_CYC + 600) @(negedge clk);
    count_high(n); check("R7 stuck high measures 255", n, 256);

    // R6 full duty keeps host value
    wr(8'h00, 8'd77);
    wr(8'h01, 8'h01);
    repeat (600) @(negedge clk);
    count_high(n); check("R6 full duty identity", n, 77);

    // R7 stuck low -> 0, R11
    ext_mode = 2;
    wr(8'h01, 8'h03);
    repeat (TO_CYC + 600) @(negedge clk);
    count_high(n); check("R7 stuck low measures 0", n, 0);
    check("R11 status off at zero", bl_on, 0);

    // R9 disable at once
    wr(8'h00, 8'd255);
    wr(8'h01, 8'h05);
    repeat (600) @(negedge clk);
    check("R9 on before disable", bl_on, 1);
    @(negedge clk);
    reg_addr = 8'h01; reg_wdata = 8'h04; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R9 output low after disable", pwm_out, 0);
    check("R9 status low after disable", bl_on, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule